// File: doc/BRIEF.md
# L2 SRAM/Cache Partition Address Decoder

This block sits in front of one core's 512KB local memory in a multicore system. It classifies every memory request that reaches that memory. A 3-bit partition mode, written by software through a small register port, decides how much of the 512KB window is kept back for the cache. The cache share is always taken from the top of the window. The rest of the window is directly addressed SRAM.

Each request carries a 32-bit address, a master ID, a local-path flag and a flag that marks accesses made by the cache controller. An address whose top byte is zero is a local alias. It is honoured only when the owning core presents it on its local path; the decoder then writes the core's global prefix (0x10 plus the core number) into the top byte. A zero-prefixed address from anyone else passes through unchanged and therefore misses.

One cycle later the decoder reports:
- the translated global address;
- whether the target is SRAM (with the byte offset into the window);
- whether the target is the cache-reserved region;
- an error when a direct data access lands in that region.

Top module: `l2_part_decoder`

## Requirements
- R1: While rst_ni is low, and in the cycle after, every output is zero. The mode then holds code 0, so the whole window at global 0x1N80_0000..0x1N87_FFFF (N = core number) reads as SRAM.
- R2: vld_o equals req_valid_i of the previous cycle. While vld_o is low, every other output is zero.
- R3: A valid request whose address has top byte 0x10|N and bits 23:19 equal to 5'b10000 targets this core. gaddr_o then equals the request address.
- R4: An address with top byte 0x00, presented with req_local_i=1 and req_mid_i=N, becomes {0x10|N, addr[23:0]} and is decoded as a global address.
- R5: A top-byte-0x00 address is treated as a plain global address when req_local_i=0 or req_mid_i differs from N. gaddr_o then equals the input, and sram_sel_o, cache_hit_o and err_o stay low.
- R6: The mode sets the size of the cache region at the top of the window: code 0 gives none, 1 gives 32KB, 2 gives 64KB, 3 gives 128KB, 4 gives 256KB and 5 gives all 512KB. An in-window offset at or above 512KB minus that size raises cache_hit_o.
- R7: For an in-window target outside the cache region, sram_sel_o=1 and sram_off_o=address bits 18:0. Otherwise sram_off_o=0. sram_sel_o and cache_hit_o are never both high.
- R8: err_o pulses for one cycle when cache_hit_o is high for a request with req_cache_i=0. Cache-controller accesses (req_cache_i=1) raise no error.
- R9: A mode write with data 6 or 7 is ignored, and the previous mode stays in force.
- R10: A request in the same cycle as a mode write is decoded with the old mode. Requests from the next cycle on use the new mode.
- R11: Any other address (wrong top byte, or bits 23:19 not 5'b10000) gives vld_o only, with every flag low and gaddr_o equal to the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Partition mode write enable |
| mode_wdata_i | input | 3 | Partition mode write data |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Request byte address |
| req_mid_i | input | MID_W | Requesting master ID |
| req_local_i | input | 1 | Request arrives on the owning core's local path |
| req_cache_i | input | 1 | Request is issued by the cache controller |
| vld_o | output | 1 | Registered response valid |
| sram_sel_o | output | 1 | Target is in SRAM |
| sram_off_o | output | 19 | Byte offset into the SRAM window |
| cache_hit_o | output | 1 | Target is in the cache-reserved region |
| err_o | output | 1 | Direct access into the cache region |
| gaddr_o | output | 32 | Translated global address |

## Verification
A mode write and a request can fall in the same cycle, and the request must then see the old partition. The bench provokes this directly by writing code 1 while it requests offset 0x78000, which must come back as SRAM; the same request one cycle later must come back as a cache hit with an error. Random traffic repeats the collision many times, with legal and reserved codes and with addresses clustered on every boundary. Each result is judged against a bench model that applies a write only after the request of the same cycle has been scored.

// File: rtl/l2_part_pkg.sv
package l2_part_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PFX_W  = 8;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_ALL_SRAM = 3'd0,
    PM_C32K     = 3'd1,
    PM_C64K     = 3'd2,
    PM_C128K    = 3'd3,
    PM_C256K    = 3'd4,
    PM_ALL_CACHE= 3'd5
  } part_mode_e;

  function automatic logic [PFX_W-1:0] core_prefix(input int unsigned core);
    return PFX_W'(8'h10 | core[3:0]);
  endfunction
endpackage

// File: rtl/l2_mode_reg.sv
module l2_mode_reg #(
  parameter int unsigned MODE_W  = 3,
  parameter int unsigned N_LEGAL = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;
  logic              legal;

  // codes at or above N_LEGAL are reserved
  assign legal = ({1'b0, wdata_i} < (MODE_W+1)'(N_LEGAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mode_q <= '0;
    else if (we_i && legal)  mode_q <= wdata_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/l2_alias_xlate.sv
module l2_alias_xlate #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PFX_W   = 8,
  parameter int unsigned MID_W   = 4,
  parameter int unsigned CORE_ID = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic              local_i,
  output logic [ADDR_W-1:0] gaddr_o
);
  localparam logic [PFX_W-1:0] PFX     = l2_part_pkg::core_prefix(CORE_ID);
  localparam logic [MID_W-1:0] OWN_MID = MID_W'(CORE_ID);

  logic owner, alias_ok;

  assign owner    = local_i && (mid_i == OWN_MID);
  assign alias_ok = owner && (addr_i[ADDR_W-1 -: PFX_W] == '0);
  assign gaddr_o  = alias_ok ? {PFX, addr_i[ADDR_W-PFX_W-1:0]} : addr_i;
endmodule

// File: rtl/l2_region_decode.sv
module l2_region_decode #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned PFX_W        = 8,
  parameter int unsigned MODE_W       = 3,
  parameter int unsigned MEM_AW       = 19,
  parameter int unsigned CACHE_MIN_AW = 15,
  parameter int unsigned CORE_ID      = 0,
  parameter logic [31:0] LOCAL_BASE   = 32'h0080_0000
) (
  input  logic [ADDR_W-1:0] gaddr_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              in_win_o,
  output logic              in_cache_o,
  output logic [MEM_AW-1:0] off_o
);
  localparam int unsigned N_CODES = MEM_AW - CACHE_MIN_AW + 2;
  localparam int unsigned N_SLOTS = 1 << MODE_W;
  localparam int unsigned TAG_HI  = ADDR_W - PFX_W - 1;
  localparam logic [PFX_W-1:0]       PFX = l2_part_pkg::core_prefix(CORE_ID);
  localparam logic [TAG_HI-MEM_AW:0] TAG = LOCAL_BASE[TAG_HI:MEM_AW];

  logic [N_SLOTS-1:0] above;

  assign off_o    = gaddr_i[MEM_AW-1:0];
  assign in_win_o = (gaddr_i[ADDR_W-1 -: PFX_W] == PFX) &&
                    (gaddr_i[TAG_HI:MEM_AW] == TAG);

  // per-code comparison against the start of the carved-out top region
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_thr
    if (g == 0 || g >= N_CODES) begin : g_none
      assign above[g] = 1'b0;
    end else begin : g_cmp
      localparam longint unsigned SZ    = 64'd1 << (CACHE_MIN_AW + g - 1);
      localparam logic [MEM_AW:0] START = (MEM_AW+1)'((64'd1 << MEM_AW) - SZ);
      assign above[g] = ({1'b0, off_o} >= START);
    end
  end

  assign in_cache_o = in_win_o && above[mode_i];
endmodule

// File: rtl/l2_part_decoder.sv
module l2_part_decoder #(
  parameter int unsigned CORE_ID      = 0,
  parameter int unsigned MID_W        = 4,
  parameter int unsigned MEM_AW       = 19,
  parameter int unsigned CACHE_MIN_AW = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [2:0]       mode_wdata_i,
  input  logic             req_valid_i,
  input  logic [31:0]      req_addr_i,
  input  logic [MID_W-1:0] req_mid_i,
  input  logic             req_local_i,
  input  logic             req_cache_i,
  output logic             vld_o,
  output logic             sram_sel_o,
  output logic [18:0]      sram_off_o,
  output logic             cache_hit_o,
  output logic             err_o,
  output logic [31:0]      gaddr_o
);
  import l2_part_pkg::*;

  localparam int unsigned N_CODES = MEM_AW - CACHE_MIN_AW + 2;

  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] gaddr;
  logic              in_win, in_cache;
  logic [MEM_AW-1:0] off;
  logic              sram_d, cache_d, err_d;

  l2_mode_reg #(.MODE_W(MODE_W), .N_LEGAL(N_CODES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_q)
  );

  l2_alias_xlate #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .MID_W(MID_W), .CORE_ID(CORE_ID)) u_xlate (
    .addr_i  (req_addr_i),
    .mid_i   (req_mid_i),
    .local_i (req_local_i),
    .gaddr_o (gaddr)
  );

  l2_region_decode #(
    .ADDR_W(ADDR_W), .PFX_W(PFX_W), .MODE_W(MODE_W), .MEM_AW(MEM_AW),
    .CACHE_MIN_AW(CACHE_MIN_AW), .CORE_ID(CORE_ID)
  ) u_region (
    .gaddr_i    (gaddr),
    .mode_i     (mode_q),
    .in_win_o   (in_win),
    .in_cache_o (in_cache),
    .off_o      (off)
  );

  assign cache_d = in_cache;
  assign sram_d  = in_win && !in_cache;
  assign err_d   = in_cache && !req_cache_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      sram_sel_o  <= 1'b0;
      sram_off_o  <= '0;
      cache_hit_o <= 1'b0;
      err_o       <= 1'b0;
      gaddr_o     <= '0;
    end else begin
      vld_o       <= req_valid_i;
      sram_sel_o  <= req_valid_i && sram_d;
      sram_off_o  <= (req_valid_i && sram_d) ? 19'(off) : '0;
      cache_hit_o <= req_valid_i && cache_d;
      err_o       <= req_valid_i && err_d;
      gaddr_o     <= req_valid_i ? gaddr : '0;
    end
  end
endmodule

// File: rtl/l2_part_decoder_chk.sv
module l2_part_decoder_chk #(
  parameter int unsigned CORE_ID = 0,
  parameter int unsigned MID_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_we_i,
  input logic [2:0]       mode_wdata_i,
  input logic             req_valid_i,
  input logic [31:0]      req_addr_i,
  input logic [MID_W-1:0] req_mid_i,
  input logic             req_local_i,
  input logic             req_cache_i,
  input logic [2:0]       mode_q,
  input logic             vld_o,
  input logic             sram_sel_o,
  input logic [18:0]      sram_off_o,
  input logic             cache_hit_o,
  input logic             err_o,
  input logic [31:0]      gaddr_o
);
  localparam logic [MID_W-1:0] OWN_MID = MID_W'(CORE_ID);
  localparam logic [7:0]       PFX     = l2_part_pkg::core_prefix(CORE_ID);

  AST_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vld_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !vld_o && !sram_sel_o && !cache_hit_o && !err_o && gaddr_o == '0); // R2
  AST_HIT_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_sel_o || cache_hit_o) |-> gaddr_o[31:24] == PFX); // R3
  AST_FOREIGN_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[31:24] == 8'h00 && !(req_local_i && req_mid_i == OWN_MID))
    |=> !sram_sel_o && !cache_hit_o && !err_o && gaddr_o == $past(req_addr_i)); // R5
  AST_TARGET_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sram_sel_o, cache_hit_o})); // R7
  AST_OFF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_sel_o |-> sram_off_o == '0); // R7
  AST_ERR_IN_CACHE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cache_hit_o && !sram_sel_o); // R8
  AST_FILL_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_cache_i) |=> !err_o); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q < 3'd6); // R9
  AST_MODE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(mode_we_i) && $past(mode_wdata_i) == mode_q); // R9
endmodule

bind l2_part_decoder l2_part_decoder_chk #(.CORE_ID(CORE_ID), .MID_W(MID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_mid_i(req_mid_i),
  .req_local_i(req_local_i), .req_cache_i(req_cache_i), .mode_q(mode_q),
  .vld_o(vld_o), .sram_sel_o(sram_sel_o), .sram_off_o(sram_off_o),
  .cache_hit_o(cache_hit_o), .err_o(err_o), .gaddr_o(gaddr_o)
);

// File: tb/l2_part_decoder_tb_top.sv
module l2_part_decoder_tb_top;
  localparam int unsigned CORE = 2;
  localparam logic [7:0]  PFX  = 8'h12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [2:0]  mode_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [3:0]  req_mid_i = '0;
  logic        req_local_i = 1'b0;
  logic        req_cache_i = 1'b0;
  logic        vld_o, sram_sel_o, cache_hit_o, err_o;
  logic [18:0] sram_off_o;
  logic [31:0] gaddr_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [2:0] m_mode = 3'd0;

  always #4 clk_i = ~clk_i;

  l2_part_decoder #(.CORE_ID(CORE)) dut_i (.*);

  function automatic int unsigned cache_bytes(input logic [2:0] m);
    case (m)
      3'd1: return 32'd32768;
      3'd2: return 32'd65536;
      3'd3: return 32'd131072;
      3'd4: return 32'd262144;
      3'd5: return 32'd524288;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [55:0] act, input logic [55:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one request (optionally with a mode write), checked one cycle later
  task automatic step(input string tag, input logic we, input logic [2:0] wd,
                      input logic v, input logic [31:0] a, input logic [3:0] mid,
                      input logic loc, input logic cf);
    logic [31:0] g;
    logic        hit, inc, sr, er;
    logic [18:0] off;
    mode_we_i = we; mode_wdata_i = wd; req_valid_i = v; req_addr_i = a;
    req_mid_i = mid; req_local_i = loc; req_cache_i = cf;
    g   = (a[31:24] == 8'h00 && loc && mid == 4'(CORE)) ? {PFX, a[23:0]} : a;
    hit = (g[31:24] == PFX) && (g[23:19] == 5'b10000);
    off = g[18:0];
    inc = hit && cache_bytes(m_mode) != 0 && (32'(off) >= 32'd524288 - cache_bytes(m_mode));
    sr  = hit && !inc;
    er  = inc && !cf;
    if (we && wd < 3'd6) m_mode = wd;
    @(negedge clk_i);
    mode_we_i = 1'b0; req_valid_i = 1'b0;
    cmp(tag, {vld_o, sram_sel_o, cache_hit_o, err_o, sram_off_o, gaddr_o},
        {v, v & sr, v & inc, v & er, (v & sr) ? off : 19'd0, v ? g : 32'd0});
  endtask

  function automatic logic [31:0] rnd_addr();
    int unsigned r = $urandom % 8;
    logic [7:0]  top;
    logic [4:0]  mid5;
    logic [18:0] lo;
    case (r)
      0, 1: top = 8'h00;
      2, 3, 4: top = PFX;
      5: top = 8'h13;
      default: top = 8'($urandom);
    endcase
    mid5 = ($urandom % 4 != 0) ? 5'b10000 : 5'($urandom);
    lo = 19'($urandom);
    if ($urandom % 3 == 0)
      lo = 19'(32'd524288 - (32'd32768 << ($urandom % 5)) + 32'($urandom % 3) - 32'd1);
    return {top, 3'b000, mid5, lo};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    cmp("R1 reset", {vld_o, sram_sel_o, cache_hit_o, err_o, sram_off_o, gaddr_o}, 56'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R1 post-reset", {vld_o, sram_sel_o, cache_hit_o, err_o, sram_off_o, gaddr_o}, 56'd0);
    step("R2 idle", 0, 0, 0, 32'h1287_FFFF, 4'd2, 1, 0);
    step("R1 mode0 top", 0, 0, 1, 32'h1287_FFFF, 4'd2, 1, 0);
    step("R3 global base", 0, 0, 1, 32'h1280_0000, 4'd7, 0, 0);
    step("R4 own alias", 0, 0, 1, 32'h0080_1234, 4'd2, 1, 0);
    step("R5 foreign mid", 0, 0, 1, 32'h0080_1234, 4'd3, 1, 0);
    step("R5 not local", 0, 0, 1, 32'h0080_1234, 4'd2, 0, 0);
    step("R11 other core", 0, 0, 1, 32'h1380_0000, 4'd2, 1, 0);
    step("R11 off window", 0, 0, 1, 32'h1290_0000, 4'd2, 1, 0);
    step("R10 write same cycle", 1, 3'd1, 1, 32'h1287_8000, 4'd2, 1, 0);
    step("R10 next cycle R8", 0, 0, 1, 32'h1287_8000, 4'd2, 1, 0);
    step("R6 below 32K", 0, 0, 1, 32'h1287_7FFF, 4'd2, 1, 0);
    step("R8 fill no err", 0, 0, 1, 32'h1287_8000, 4'd2, 1, 1);
    for (int m = 2; m <= 4; m++) begin
      logic [31:0] st = 32'h1288_0000 - (32'h8000 << (m - 1));
      step("R6 write", 1, 3'(m), 0, 32'h0, 4'd0, 0, 0);
      step("R6 start", 0, 0, 1, st, 4'd5, 0, 0);
      step("R6 start-1", 0, 0, 1, st - 1, 4'd5, 0, 0);
    end
    step("R6 all cache", 1, 3'd5, 0, 32'h0, 4'd0, 0, 0);
    step("R6 base is cache", 0, 0, 1, 32'h0080_0000, 4'd2, 1, 0);
    step("R9 write 110", 1, 3'd6, 0, 32'h0, 4'd0, 0, 0);
    step("R9 mode kept", 0, 0, 1, 32'h1280_0000, 4'd2, 0, 0);
    step("R9 write 111", 1, 3'd7, 0, 32'h0, 4'd0, 0, 0);
    step("R9 mode kept", 0, 0, 1, 32'h1280_0000, 4'd2, 0, 1);
    step("R1 back to sram", 1, 3'd0, 1, 32'h1280_0000, 4'd2, 1, 0);
    step("R7 sram offset", 0, 0, 1, 32'h1285_4321, 4'd2, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      step("R6/R7/R10 random", ($urandom % 6 == 0), 3'($urandom), ($urandom % 5 != 0),
           rnd_addr(), ($urandom % 2 == 0) ? 4'(CORE) : 4'($urandom),
           1'($urandom), ($urandom % 4 == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule